// File: doc/BRIEF.md
# Paged DMA Address and Count Generator

This block sequences one DMA channel. It keeps a page register, a 16-bit current address, a 16-bit transfer count and base copies of the address and count. From the page and the current address it forms a 24-bit physical address, so transfers stay in the lowest 16 MB. Each accepted transfer-done pulse moves the address up by one and the count down by one. When the count has run out, the block raises a one-cycle terminal-count pulse.

The programmed count is one less than the number of transfers. In byte mode the page supplies bits 23:16 and the window is 64 KB. In word mode the address is shifted left by one, page bit 0 is dropped and the window is 128 KB. The page register is never stepped, so the address wraps inside its window.

At terminal count the channel either reloads address and count from their base copies (autoinit) or masks itself and ignores later pulses until a new count is written. Bus handshake, arbitration between channels and the CPU register decode are handled elsewhere.

Top module: `dma_page_seq`

## Requirements
- R1: After reset the page, address and count are 0. The channel is masked (active_o=0), tc_o=0 and phys_addr_o=0.
- R2: When word_mode_i=0, phys_addr_o = {page[7:0], addr[15:0]} and word_o=0. byte_en_o is 2'b01 for an even address and 2'b10 for an odd address.
- R3: When word_mode_i=1, phys_addr_o = {page[7:1], addr[15:0], 1'b0}, page bit 0 is ignored, byte_en_o=2'b11 and word_o=1.
- R4: Each accepted xfer_done_i pulse adds 1 to the current address and takes 1 from the count. The address wraps from 0xFFFF to 0x0000 and leaves the page unchanged.
- R5: A programmed count N gives N+1 transfers, so 0x0000 gives 1 and 0xFFFF gives 65536. tc_o is high for the one cycle after the edge that takes the last transfer.
- R6: With autoinit_i=0, active_o falls at terminal count. Later xfer_done_i pulses then change neither the address nor tc_o.
- R7: With autoinit_i=1, terminal count reloads the current address and count from their base copies and active_o stays 1.
- R8: A count_we_i strobe loads both the base and the current count and sets active_o=1. An xfer_done_i in the same cycle is ignored: no step and no tc_o.
- R9: A base_addr_we_i strobe loads both the base and the current address. It takes priority over a step in the same cycle.
- R10: Only page_we_i changes the page. Bits 23:17 of phys_addr_o equal page[7:1] in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_mode_i | input | 1 | 1 selects word transfers, 0 selects byte transfers |
| autoinit_i | input | 1 | Reload from the base copies at terminal count |
| page_we_i | input | 1 | Page load strobe |
| page_i | input | 8 | Page value |
| base_addr_we_i | input | 1 | Address load strobe (base and current) |
| base_addr_i | input | 16 | Address value |
| count_we_i | input | 1 | Count load strobe (base and current), unmasks the channel |
| count_i | input | 16 | Number of transfers minus one |
| xfer_done_i | input | 1 | One transfer finished |
| phys_addr_o | output | 24 | Physical address of the next transfer |
| byte_en_o | output | 2 | Byte lanes used by the next transfer |
| word_o | output | 1 | The next transfer is a 16-bit word |
| active_o | output | 1 | Channel is unmasked |
| tc_o | output | 1 | Terminal-count pulse |

## Verification
Two collisions matter here. The first is a count load strobe in the same cycle as a transfer-done pulse. The bench raises both on one edge while the count is at zero. It then expects no tc_o, an unchanged address, an active channel, and exactly one tc_o on the next single pulse. The second is an address load in the same cycle as a step. The bench expects the loaded address to appear rather than the incremented one, while the count still steps.

// File: rtl/dma_page_seq_pkg.sv
package dma_page_seq_pkg;
  typedef enum logic {XFER_BYTE = 1'b0, XFER_WORD = 1'b1} xfer_mode_e;

  function automatic logic [1:0] lane_enables(xfer_mode_e mode, logic addr_lsb);
    if (mode == XFER_WORD) return 2'b11;
    return addr_lsb ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          reload_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load_i) begin
      base_q <= load_val_i;
      cur_q  <= load_val_i;
    end else if (reload_i) begin
      cur_q  <= base_q;
    end else if (step_i) begin
      cur_q  <= cur_q + AW'(1); // wraps inside the window
    end
  end

  assign addr_o = cur_q;
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          autoinit_i,
  output logic          last_o,
  output logic          tc_o
);
  logic [CW-1:0] base_q, cur_q;
  logic          tc_q;

  assign last_o = (cur_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
      tc_q   <= 1'b0;
    end else begin
      tc_q <= step_i && last_o;
      if (load_i) begin
        base_q <= load_val_i;
        cur_q  <= load_val_i;
      end else if (step_i) begin
        cur_q  <= (last_o && autoinit_i) ? base_q : cur_q - CW'(1);
      end
    end
  end

  assign tc_o = tc_q;
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map
  import dma_page_seq_pkg::*;
#(
  parameter int PW = 8,
  parameter int AW = 16,
  localparam int XW = PW + AW
) (
  input  logic          word_i,
  input  logic [PW-1:0] page_i,
  input  logic [AW-1:0] addr_i,
  output logic [XW-1:0] phys_o,
  output logic [1:0]    byte_en_o
);
  xfer_mode_e mode;
  assign mode = word_i ? XFER_WORD : XFER_BYTE;

  always_comb begin
    if (mode == XFER_WORD) phys_o = {page_i[PW-1:1], addr_i, 1'b0};
    else                   phys_o = {page_i, addr_i};
  end

  assign byte_en_o = lane_enables(mode, addr_i[0]);
endmodule

// File: rtl/dma_page_seq.sv
module dma_page_seq #(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int PHYS_W = PAGE_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_mode_i,
  input  logic              autoinit_i,
  input  logic              page_we_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              base_addr_we_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              count_we_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              xfer_done_i,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic [1:0]        byte_en_o,
  output logic              word_o,
  output logic              active_o,
  output logic              tc_o
);
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] addr;
  logic              mask_q, step, last, reload;

  // count load wins over a coincident transfer
  assign step   = xfer_done_i && !mask_q && !count_we_i;
  assign reload = step && last && autoinit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      mask_q <= 1'b1;
    end else begin
      if (page_we_i) page_q <= page_i;
      if (count_we_i)                       mask_q <= 1'b0;
      else if (step && last && !autoinit_i) mask_q <= 1'b1;
    end
  end

  dma_addr_ctr #(.AW(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (base_addr_we_i),
    .load_val_i (base_addr_i),
    .step_i     (step),
    .reload_i   (reload),
    .addr_o     (addr)
  );

  dma_xfer_cnt #(.CW(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (count_we_i),
    .load_val_i (count_i),
    .step_i     (step),
    .autoinit_i (autoinit_i),
    .last_o     (last),
    .tc_o       (tc_o)
  );

  dma_phys_map #(.PW(PAGE_W), .AW(ADDR_W)) u_map (
    .word_i    (word_mode_i),
    .page_i    (page_q),
    .addr_i    (addr),
    .phys_o    (phys_addr_o),
    .byte_en_o (byte_en_o)
  );

  assign word_o   = word_mode_i;
  assign active_o = !mask_q;
endmodule

// File: rtl/dma_page_seq_chk.sv
module dma_page_seq_chk #(
  parameter int PHYS_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_mode_i,
  input logic              page_we_i,
  input logic              count_we_i,
  input logic              xfer_done_i,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic [1:0]        byte_en_o,
  input logic              active_o,
  input logic              tc_o
);
  assert_tc_follows_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> $past(xfer_done_i));

  assert_mask_only_at_tc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> tc_o);

  assert_load_unmasks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_we_i |=> active_o);

  assert_load_blocks_tc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_we_i |=> !tc_o);

  assert_page_bits_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_we_i |=> $stable(phys_addr_o[PHYS_W-1:PHYS_W-7]));

  assert_one_lane_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_mode_i |-> $countones(byte_en_o) == 1);
endmodule

bind dma_page_seq dma_page_seq_chk #(.PHYS_W(PHYS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_mode_i (word_mode_i),
  .page_we_i   (page_we_i),
  .count_we_i  (count_we_i),
  .xfer_done_i (xfer_done_i),
  .phys_addr_o (phys_addr_o),
  .byte_en_o   (byte_en_o),
  .active_o    (active_o),
  .tc_o        (tc_o)
);

// File: tb/dma_page_seq_bench.sv
`timescale 1ns/1ps
module dma_page_seq_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        word_mode = 1'b0, autoinit = 1'b0;
  logic        page_we = 1'b0, addr_we = 1'b0, count_we = 1'b0, done = 1'b0;
  logic [7:0]  page_v = '0;
  logic [15:0] addr_v = '0, count_v = '0;
  logic [23:0] phys;
  logic [1:0]  ben;
  logic        word_f, active, tc;

  int errors = 0, checks = 0, tc_seen = 0, last_tc_idx = -1;

  always #4 clk = ~clk;

  dma_page_seq u_dma_page_seq (
    .clk_i(clk), .rst_ni(rst_n), .word_mode_i(word_mode), .autoinit_i(autoinit),
    .page_we_i(page_we), .page_i(page_v), .base_addr_we_i(addr_we), .base_addr_i(addr_v),
    .count_we_i(count_we), .count_i(count_v), .xfer_done_i(done),
    .phys_addr_o(phys), .byte_en_o(ben), .word_o(word_f), .active_o(active), .tc_o(tc)
  );

  typedef struct packed {
    logic        word;
    logic        auto_en;
    logic [7:0]  page;
    logic [15:0] base;
    logic [15:0] cnt;
    logic [7:0]  pulses;
    logic [23:0] exp_phys;
    logic        exp_active;
    logic [3:0]  exp_tcs;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'h12, 16'h3400, 16'h0003, 8'd2, 24'h123402, 1'b1, 4'd0},
    '{1'b0, 1'b0, 8'h12, 16'h3400, 16'h0003, 8'd4, 24'h123404, 1'b0, 4'd1},
    '{1'b0, 1'b0, 8'h12, 16'h3400, 16'h0001, 8'd5, 24'h123402, 1'b0, 4'd1},
    '{1'b0, 1'b0, 8'h56, 16'hFFFE, 16'h0005, 8'd3, 24'h560001, 1'b1, 4'd0},
    '{1'b1, 1'b0, 8'h57, 16'h1234, 16'h0002, 8'd1, 24'h56246A, 1'b1, 4'd0},
    '{1'b1, 1'b1, 8'h80, 16'h0010, 16'h0001, 8'd2, 24'h800020, 1'b1, 4'd1},
    '{1'b1, 1'b1, 8'h80, 16'h0010, 16'h0001, 8'd5, 24'h800022, 1'b1, 4'd2},
    '{1'b0, 1'b1, 8'hFF, 16'hFFFF, 16'h0000, 8'd3, 24'hFFFFFF, 1'b1, 4'd3},
    '{1'b1, 1'b0, 8'h01, 16'hFFFF, 16'h0000, 8'd1, 24'h000000, 1'b0, 4'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load_chan(input logic [7:0] p, input logic [15:0] a, input logic [15:0] c);
    @(negedge clk);
    page_we = 1'b1; page_v = p; addr_we = 1'b1; addr_v = a; count_we = 1'b1; count_v = c;
    @(negedge clk);
    page_we = 1'b0; addr_we = 1'b0; count_we = 1'b0;
  endtask

  // back-to-back transfer pulses, tc_o sampled after each edge
  task automatic burst(input int n);
    tc_seen = 0; last_tc_idx = -1;
    if (n > 0) begin
      @(negedge clk);
      done = 1'b1;
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        if (tc) begin tc_seen++; last_tc_idx = i; end
      end
      done = 1'b0;
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 phys", 32'(phys), 0);
    chk("R1 active", 32'(active), 0);
    chk("R1 tc", 32'(tc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // a masked channel ignores pulses
    burst(2);
    chk("R1 masked ignores done", 32'(phys), 0);

    for (int v = 0; v < NV; v++) begin
      word_mode = VECS[v].word;
      autoinit  = VECS[v].auto_en;
      load_chan(VECS[v].page, VECS[v].base, VECS[v].cnt);
      burst(int'(VECS[v].pulses));
      @(negedge clk);
      chk($sformatf("R4/R3/R2 vec%0d phys", v), 32'(phys), 32'(VECS[v].exp_phys));
      chk($sformatf("R6/R7 vec%0d active", v), 32'(active), 32'(VECS[v].exp_active));
      chk($sformatf("R5 vec%0d tc count", v), tc_seen, 32'(VECS[v].exp_tcs));
    end

    // R2 lanes: odd and even byte addresses
    word_mode = 1'b0; autoinit = 1'b0;
    load_chan(8'h20, 16'h0005, 16'h0010);
    chk("R2 odd lane", 32'(ben), 32'b10);
    chk("R2 word flag", 32'(word_f), 0);
    burst(1);
    chk("R2 even lane", 32'(ben), 32'b01);
    // R3 word lanes and page bit 0 ignored
    word_mode = 1'b1;
    @(negedge clk);
    chk("R3 lanes", 32'(ben), 32'b11);
    chk("R3 word flag", 32'(word_f), 1);
    chk("R3 phys", 32'(phys), 32'h20000C);
    // R10 page write alone moves the page field
    @(negedge clk); page_we = 1'b1; page_v = 8'h21;
    @(negedge clk); page_we = 1'b0;
    chk("R10 page bit0 ignored", 32'(phys), 32'h20000C);
    word_mode = 1'b0;
    @(negedge clk);
    chk("R10 byte page", 32'(phys), 32'h210006);

    // R5 full 65536-transfer count
    load_chan(8'h00, 16'h0000, 16'hFFFF);
    burst(65536);
    chk("R5 full count tc once", tc_seen, 1);
    chk("R5 full count tc on last", last_tc_idx, 65535);
    chk("R6 masked after full count", 32'(active), 0);
    chk("R4 wrapped address", 32'(phys), 0);

    // R8 count load collides with a transfer at zero count
    load_chan(8'h30, 16'h0040, 16'h0000);
    @(negedge clk);
    count_we = 1'b1; count_v = 16'h0000; done = 1'b1;
    @(negedge clk);
    count_we = 1'b0; done = 1'b0;
    chk("R8 no tc on collision", 32'(tc), 0);
    chk("R8 no step on collision", 32'(phys), 32'h300040);
    chk("R8 active", 32'(active), 1);
    burst(1);
    chk("R8 one tc after", tc_seen, 1);

    // R9 address load collides with a step
    load_chan(8'h30, 16'h0040, 16'h0001);
    @(negedge clk);
    addr_we = 1'b1; addr_v = 16'h0100; done = 1'b1;
    @(negedge clk);
    addr_we = 1'b0; done = 1'b0;
    chk("R9 load wins", 32'(phys), 32'h300100);
    burst(1);
    chk("R9 count still stepped", tc_seen, 1);

    // R6 pulses after mask are ignored
    burst(3);
    chk("R6 no tc when masked", tc_seen, 0);
    chk("R6 address frozen", 32'(phys), 32'h300101);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule